// File: doc/BRIEF.md
# Load-Use Hazard and Forwarding Control

This block makes the per-cycle hazard decisions for a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and writeback. The block looks at the register numbers and qualifier flags held in the decode, execute, memory and writeback pipeline registers. From these it decides three things. It decides whether decode and fetch must hold. It decides whether a bubble goes into execute. It also picks a bypass source for each operand of the instruction now in execute. It holds no state, and every output is a combinational function of the current inputs.

Load data first exists at the end of the memory stage. A consumer directly behind a load can therefore never take that result from a bypass. A mode input picks how this case is handled. In delay-slot mode, software owns the slot after a load, and the consumer reads the older value. In interlock mode, the block stalls for one cycle. A build-time mask can leave out either bypass path. A dependence that would need a missing path then holds decode until the register file can supply the value. Writeback-stage producers never need help, because the register file passes a same-cycle write through to its read ports.

Top module: `hz_unit`

## Requirements
- R1: With `mode_interlock_i`=1, a valid decode operand that is in use, is nonzero and equals the destination of a valid, writing load in execute drives `stall_o`=1, `bubble_o`=1 and `issue_valid_o`=0 for every mask.
- R2: With `mode_interlock_i`=0, such a load in execute causes no stall. It also hides itself from that operand, so the nearest older producer in memory is the one considered for R8.
- R3: An execute operand never takes the memory-stage bypass when the memory-stage instruction is a load. The operand takes the writeback bypass if writeback matches, and the register file otherwise.
- R4: Each `fwd_sel_o` entry is one-hot, with bit 0 for the register file, bit 1 for the memory-stage (execute/memory result) bypass and bit 2 for the writeback-stage (memory/writeback result) bypass. A non-load memory match wins over a writeback match. With no match, the register file is selected.
- R5: Register 0 never causes a stall and never selects a bypass.
- R6: A stage with its valid flag or its write-enable flag low never matches.
- R7: With `FWD_MASK[0]`=0 (no memory-stage bypass), a decode operand whose nearest producer is a non-load in execute stalls, and bit 1 of `fwd_sel_o` is never set.
- R8: With `FWD_MASK[1]`=0 (no writeback-stage bypass), a decode operand whose nearest producer is in memory stalls, and bit 2 of `fwd_sel_o` is never set.
- R9: `bubble_o` equals `stall_o`, `issue_valid_o` equals `dec_valid_i` with `stall_o` low, and a stall never occurs while decode is invalid.
- R10: A decode operand whose use flag is 0, or an execute operand whose use flag is 0, never stalls and selects the register file.
- R11: A producer in writeback alone never stalls a decode operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_interlock_i | input | 1 | 1 = hardware interlock, 0 = software load delay slot |
| dec_valid_i | input | 1 | Decode slot holds a real instruction |
| dec_use_i | input | NUM_SRC | Per-operand use flags of the decode instruction |
| dec_src_i | input | NUM_SRC x REG_BITS | Source register numbers in decode |
| ex_valid_i | input | 1 | Execute slot holds a real instruction |
| ex_wen_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| ex_dst_i | input | REG_BITS | Destination register of execute |
| ex_use_i | input | NUM_SRC | Per-operand use flags of the execute instruction |
| ex_src_i | input | NUM_SRC x REG_BITS | Source register numbers in execute |
| mem_valid_i | input | 1 | Memory slot holds a real instruction |
| mem_wen_i | input | 1 | Memory instruction writes a register |
| mem_load_i | input | 1 | Memory instruction is a load |
| mem_dst_i | input | REG_BITS | Destination register of memory stage |
| wb_valid_i | input | 1 | Writeback slot holds a real instruction |
| wb_wen_i | input | 1 | Writeback instruction writes a register |
| wb_dst_i | input | REG_BITS | Destination register of writeback |
| stall_o | output | 1 | Hold fetch and decode this cycle |
| bubble_o | output | 1 | Load an empty slot into execute |
| issue_valid_o | output | 1 | Valid marker for the slot entering execute (0 on bubbles) |
| fwd_sel_o | output | NUM_SRC x 3 | One-hot bypass select per execute operand |

## Verification
The assertions assume that the pipeline around the block respects its stalls. Under that assumption, a consumer never sits in execute while a load it depends on is in memory, and it never needs a bypass path that the mask leaves out. The checks on selects and masks only hold under that assumption. The stimulus is a table of pipeline snapshots, each written on its own, and includes snapshots where a memory-stage load matches an execute operand. Those snapshots only occur in delay-slot mode, where reading the older value is the intended behaviour. Every assertion is immediate and purely combinational, so no snapshot depends on earlier ones.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_RF = 3'b001;
  localparam logic [SEL_W-1:0] SEL_XM = 3'b010;
  localparam logic [SEL_W-1:0] SEL_MW = 3'b100;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int REG_BITS = 5
) (
  input  logic                use_i,
  input  logic [REG_BITS-1:0] src_i,
  input  logic                valid_i,
  input  logic                wen_i,
  input  logic [REG_BITS-1:0] dst_i,
  output logic                hit_o
);
  function automatic logic reg_hit(input logic u, input logic [REG_BITS-1:0] s,
                                   input logic v, input logic w,
                                   input logic [REG_BITS-1:0] d);
    return u && v && w && (s != '0) && (s == d);
  endfunction

  assign hit_o = reg_hit(use_i, src_i, valid_i, wen_i, dst_i);
endmodule

// File: rtl/hz_dec_check.sv
module hz_dec_check #(
  parameter int REG_BITS = 5,
  parameter bit HAS_XM   = 1'b1,
  parameter bit HAS_MW   = 1'b1
) (
  input  logic                mode_interlock_i,
  input  logic                use_i,
  input  logic [REG_BITS-1:0] src_i,
  input  logic                ex_valid_i,
  input  logic                ex_wen_i,
  input  logic                ex_load_i,
  input  logic [REG_BITS-1:0] ex_dst_i,
  input  logic                mem_valid_i,
  input  logic                mem_wen_i,
  input  logic [REG_BITS-1:0] mem_dst_i,
  output logic                load_use_o,
  output logic                path_stall_o
);
  logic hit_ex, hit_mem, slot_hidden, near_ex;

  hz_src_match #(.REG_BITS(REG_BITS)) u_ex (
    .use_i(use_i), .src_i(src_i), .valid_i(ex_valid_i), .wen_i(ex_wen_i),
    .dst_i(ex_dst_i), .hit_o(hit_ex));

  hz_src_match #(.REG_BITS(REG_BITS)) u_mem (
    .use_i(use_i), .src_i(src_i), .valid_i(mem_valid_i), .wen_i(mem_wen_i),
    .dst_i(mem_dst_i), .hit_o(hit_mem));

  always_comb begin
    // in slot mode the load right ahead is invisible to this operand
    slot_hidden  = hit_ex && ex_load_i && !mode_interlock_i;
    near_ex      = hit_ex && !slot_hidden;
    load_use_o   = near_ex && ex_load_i;
    path_stall_o = (near_ex && !ex_load_i && !HAS_XM) ||
                   (!near_ex && hit_mem && !HAS_MW);
  end
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
  import hz_pkg::*;
#(
  parameter int REG_BITS = 5,
  parameter bit HAS_XM   = 1'b1,
  parameter bit HAS_MW   = 1'b1
) (
  input  logic                use_i,
  input  logic [REG_BITS-1:0] src_i,
  input  logic                mem_valid_i,
  input  logic                mem_wen_i,
  input  logic                mem_load_i,
  input  logic [REG_BITS-1:0] mem_dst_i,
  input  logic                wb_valid_i,
  input  logic                wb_wen_i,
  input  logic [REG_BITS-1:0] wb_dst_i,
  output logic [SEL_W-1:0]    sel_o
);
  logic hit_mem, hit_wb, mem_usable, take_xm, take_mw;

  hz_src_match #(.REG_BITS(REG_BITS)) u_mem (
    .use_i(use_i), .src_i(src_i), .valid_i(mem_valid_i), .wen_i(mem_wen_i),
    .dst_i(mem_dst_i), .hit_o(hit_mem));

  hz_src_match #(.REG_BITS(REG_BITS)) u_wb (
    .use_i(use_i), .src_i(src_i), .valid_i(wb_valid_i), .wen_i(wb_wen_i),
    .dst_i(wb_dst_i), .hit_o(hit_wb));

  always_comb begin
    mem_usable = hit_mem && !mem_load_i;
    take_xm    = mem_usable && HAS_XM;
    take_mw    = hit_wb && !mem_usable && HAS_MW;
    if (take_xm)      sel_o = SEL_XM;
    else if (take_mw) sel_o = SEL_MW;
    else              sel_o = SEL_RF;
  end
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int         REG_BITS = 5,
  parameter int         NUM_SRC  = 2,
  parameter logic [1:0] FWD_MASK = 2'b11
) (
  input  logic                              mode_interlock_i,
  input  logic                              dec_valid_i,
  input  logic [NUM_SRC-1:0]                dec_use_i,
  input  logic [NUM_SRC-1:0][REG_BITS-1:0]  dec_src_i,
  input  logic                              ex_valid_i,
  input  logic                              ex_wen_i,
  input  logic                              ex_load_i,
  input  logic [REG_BITS-1:0]               ex_dst_i,
  input  logic [NUM_SRC-1:0]                ex_use_i,
  input  logic [NUM_SRC-1:0][REG_BITS-1:0]  ex_src_i,
  input  logic                              mem_valid_i,
  input  logic                              mem_wen_i,
  input  logic                              mem_load_i,
  input  logic [REG_BITS-1:0]               mem_dst_i,
  input  logic                              wb_valid_i,
  input  logic                              wb_wen_i,
  input  logic [REG_BITS-1:0]               wb_dst_i,
  output logic                              stall_o,
  output logic                              bubble_o,
  output logic                              issue_valid_o,
  output logic [NUM_SRC-1:0][SEL_W-1:0]     fwd_sel_o
);
  localparam bit HAS_XM = FWD_MASK[0];
  localparam bit HAS_MW = FWD_MASK[1];

  // named per-operand events, observed by the bound checker
  logic [NUM_SRC-1:0] op_load_use;
  logic [NUM_SRC-1:0] op_path_stall;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
    hz_dec_check #(.REG_BITS(REG_BITS), .HAS_XM(HAS_XM), .HAS_MW(HAS_MW)) u_dec (
      .mode_interlock_i(mode_interlock_i),
      .use_i(dec_valid_i && dec_use_i[g]),
      .src_i(dec_src_i[g]),
      .ex_valid_i(ex_valid_i), .ex_wen_i(ex_wen_i), .ex_load_i(ex_load_i),
      .ex_dst_i(ex_dst_i),
      .mem_valid_i(mem_valid_i), .mem_wen_i(mem_wen_i), .mem_dst_i(mem_dst_i),
      .load_use_o(op_load_use[g]),
      .path_stall_o(op_path_stall[g]));

    hz_fwd_pick #(.REG_BITS(REG_BITS), .HAS_XM(HAS_XM), .HAS_MW(HAS_MW)) u_fwd (
      .use_i(ex_valid_i && ex_use_i[g]),
      .src_i(ex_src_i[g]),
      .mem_valid_i(mem_valid_i), .mem_wen_i(mem_wen_i), .mem_load_i(mem_load_i),
      .mem_dst_i(mem_dst_i),
      .wb_valid_i(wb_valid_i), .wb_wen_i(wb_wen_i), .wb_dst_i(wb_dst_i),
      .sel_o(fwd_sel_o[g]));
  end

  always_comb begin
    stall_o       = (|op_load_use) || (|op_path_stall);
    bubble_o      = stall_o;
    issue_valid_o = dec_valid_i && !stall_o;
  end
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk
  import hz_pkg::*;
#(
  parameter int         REG_BITS = 5,
  parameter int         NUM_SRC  = 2,
  parameter logic [1:0] FWD_MASK = 2'b11
) (
  input logic                             mode_interlock_i,
  input logic                             dec_valid_i,
  input logic [NUM_SRC-1:0]               dec_use_i,
  input logic [NUM_SRC-1:0][REG_BITS-1:0] dec_src_i,
  input logic                             ex_valid_i,
  input logic                             ex_wen_i,
  input logic                             ex_load_i,
  input logic [REG_BITS-1:0]              ex_dst_i,
  input logic [NUM_SRC-1:0][REG_BITS-1:0] ex_src_i,
  input logic                             mem_load_i,
  input logic                             stall_o,
  input logic                             issue_valid_o,
  input logic [NUM_SRC-1:0][SEL_W-1:0]    fwd_sel_o,
  input logic [NUM_SRC-1:0]               op_load_use,
  input logic [NUM_SRC-1:0]               op_path_stall
);
  always_comb begin
    for (int k = 0; k < NUM_SRC; k++) begin
      // R1
      load_use_chk: assert (!(mode_interlock_i && dec_valid_i && dec_use_i[k] &&
                              ex_valid_i && ex_wen_i && ex_load_i &&
                              dec_src_i[k] != '0 && dec_src_i[k] == ex_dst_i) || stall_o);
      // R4
      onehot_sel_chk: assert ($onehot(fwd_sel_o[k]));
      // R3
      no_load_bypass_chk: assert (!(mem_load_i && fwd_sel_o[k][1]));
      // R5
      zero_dec_chk: assert (!(dec_src_i[k] == '0 && (op_load_use[k] || op_path_stall[k])));
      // R5
      zero_ex_chk: assert (!(ex_src_i[k] == '0) || fwd_sel_o[k] == SEL_RF);
      // R10
      unused_op_chk: assert (dec_use_i[k] || !(op_load_use[k] || op_path_stall[k]));
      // R7
      mask_xm_chk: assert (FWD_MASK[0] || !fwd_sel_o[k][1]);
      // R8
      mask_mw_chk: assert (FWD_MASK[1] || !fwd_sel_o[k][2]);
    end
    // R2
    slot_no_ls_chk: assert (mode_interlock_i || !stall_o || (|op_path_stall));
    // R9
    stall_needs_dec_chk: assert (!stall_o || dec_valid_i);
    // R9
    bubble_marker_chk: assert (!(issue_valid_o && stall_o));
  end
endmodule

bind hz_unit hz_unit_chk #(.REG_BITS(REG_BITS), .NUM_SRC(NUM_SRC), .FWD_MASK(FWD_MASK)) u_chk (
  .mode_interlock_i(mode_interlock_i), .dec_valid_i(dec_valid_i), .dec_use_i(dec_use_i),
  .dec_src_i(dec_src_i), .ex_valid_i(ex_valid_i), .ex_wen_i(ex_wen_i),
  .ex_load_i(ex_load_i), .ex_dst_i(ex_dst_i), .ex_src_i(ex_src_i),
  .mem_load_i(mem_load_i), .stall_o(stall_o), .issue_valid_o(issue_valid_o),
  .fwd_sel_o(fwd_sel_o), .op_load_use(op_load_use), .op_path_stall(op_path_stall));

// File: tb/sim_hz_unit.sv
`timescale 1ns/1ps
module sim_hz_unit;
  localparam int RB = 5;
  localparam int NS = 2;

  typedef struct packed {
    logic [7:0] rq;
    logic mode, dv; logic [1:0] du; logic [4:0] ds1, ds0;
    logic exv, exw, exl; logic [4:0] exd; logic [1:0] exu; logic [4:0] exs1, exs0;
    logic mv, mw, ml; logic [4:0] md;
    logic wv, ww; logic [4:0] wd;
    logic [2:0] est; logic [2:0] ef1, ef0;
  } vec_t;

  function automatic vec_t mk(int rq, int mode, int dv, int du, int ds1, int ds0,
      int exv, int exw, int exl, int exd, int exu, int exs1, int exs0,
      int mv, int mw, int ml, int md, int wv, int ww, int wd,
      int est, int ef1, int ef0);
    vec_t v;
    v.rq = rq[7:0]; v.mode = mode[0]; v.dv = dv[0]; v.du = du[1:0];
    v.ds1 = ds1[4:0]; v.ds0 = ds0[4:0];
    v.exv = exv[0]; v.exw = exw[0]; v.exl = exl[0]; v.exd = exd[4:0];
    v.exu = exu[1:0]; v.exs1 = exs1[4:0]; v.exs0 = exs0[4:0];
    v.mv = mv[0]; v.mw = mw[0]; v.ml = ml[0]; v.md = md[4:0];
    v.wv = wv[0]; v.ww = ww[0]; v.wd = wd[4:0];
    v.est = est[2:0]; v.ef1 = ef1[2:0]; v.ef0 = ef0[2:0];
    return v;
  endfunction

  // est bit0: full mask, bit1: no memory-stage bypass, bit2: no writeback bypass
  // selects: 1 = register file, 2 = memory-stage bypass, 4 = writeback bypass
  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    mk(9, 0,0,0, 0,0,  0,0,0,0, 0,0,0,  0,0,0,0,  0,0,0,  'b000, 1,1), // R9 idle
    mk(1, 1,1,1, 0,5,  1,1,1,5, 0,0,0,  0,0,0,0,  0,0,0,  'b111, 1,1), // R1
    mk(2, 0,1,1, 0,5,  1,1,1,5, 0,0,0,  0,0,0,0,  0,0,0,  'b000, 1,1), // R2
    mk(7, 1,1,1, 0,5,  1,1,0,5, 0,0,0,  0,0,0,0,  0,0,0,  'b010, 1,1), // R7
    mk(8, 1,1,1, 0,7,  0,0,0,0, 0,0,0,  1,1,0,7,  0,0,0,  'b100, 1,1), // R8
    mk(11,1,1,1, 0,9,  0,0,0,0, 0,0,0,  0,0,0,0,  1,1,9,  'b000, 1,1), // R11
    mk(5, 1,1,1, 0,0,  1,1,1,0, 0,0,0,  1,1,0,0,  0,0,0,  'b000, 1,1), // R5
    mk(6, 1,1,1, 0,5,  0,1,1,5, 0,0,0,  0,0,0,0,  0,0,0,  'b000, 1,1), // R6
    mk(6, 1,1,1, 0,5,  1,0,1,5, 0,0,0,  1,0,0,5,  0,0,0,  'b000, 1,1), // R6
    mk(10,1,1,0, 0,5,  1,1,1,5, 0,0,0,  0,0,0,0,  0,0,0,  'b000, 1,1), // R10
    mk(1, 1,1,2, 12,0, 1,1,1,12,0,0,0,  0,0,0,0,  0,0,0,  'b111, 1,1), // R1 operand 1
    mk(4, 1,0,0, 0,0,  1,1,0,1, 3,4,3,  1,1,0,3,  1,1,4,  'b000, 4,2), // R4
    mk(4, 1,0,0, 0,0,  1,1,0,1, 3,6,3,  1,1,0,3,  1,1,3,  'b000, 1,2), // R4 priority
    mk(3, 0,0,0, 0,0,  1,1,0,1, 3,3,3,  1,1,1,3,  1,1,3,  'b000, 4,4), // R3
    mk(3, 0,0,0, 0,0,  1,1,0,1, 3,0,3,  1,1,1,3,  0,0,0,  'b000, 1,1), // R3
    mk(5, 1,0,0, 0,0,  1,1,0,1, 1,0,0,  1,1,0,0,  1,1,0,  'b000, 1,1), // R5
    mk(6, 1,0,0, 0,0,  1,1,0,1, 1,0,3,  0,1,0,3,  1,0,3,  'b000, 1,1), // R6
    mk(8, 1,1,1, 0,5,  0,0,0,0, 0,0,0,  1,1,1,5,  0,0,0,  'b100, 1,1), // R8 load in memory
    mk(2, 0,1,1, 0,5,  1,1,1,5, 0,0,0,  1,1,0,5,  0,0,0,  'b100, 1,1), // R2 hidden load
    mk(10,1,1,1, 0,5,  1,1,0,5, 2,0,4,  1,1,0,5,  1,1,4,  'b010, 1,1)  // R10 ex operand unused; R7
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic mode, dv, exv, exw, exl, mv, mw, ml, wv, ww;
  logic [NS-1:0] du, exu;
  logic [NS-1:0][RB-1:0] ds, exs;
  logic [RB-1:0] exd, md, wd;
  logic st0, st1, st2, bb0, iv0, bb1, iv1, bb2, iv2;
  logic [NS-1:0][2:0] f0, f1, f2;

  hz_unit #(.REG_BITS(RB), .NUM_SRC(NS), .FWD_MASK(2'b11)) u0 (
    .mode_interlock_i(mode), .dec_valid_i(dv), .dec_use_i(du), .dec_src_i(ds),
    .ex_valid_i(exv), .ex_wen_i(exw), .ex_load_i(exl), .ex_dst_i(exd),
    .ex_use_i(exu), .ex_src_i(exs), .mem_valid_i(mv), .mem_wen_i(mw),
    .mem_load_i(ml), .mem_dst_i(md), .wb_valid_i(wv), .wb_wen_i(ww), .wb_dst_i(wd),
    .stall_o(st0), .bubble_o(bb0), .issue_valid_o(iv0), .fwd_sel_o(f0));
  hz_unit #(.REG_BITS(RB), .NUM_SRC(NS), .FWD_MASK(2'b10)) u1 (
    .mode_interlock_i(mode), .dec_valid_i(dv), .dec_use_i(du), .dec_src_i(ds),
    .ex_valid_i(exv), .ex_wen_i(exw), .ex_load_i(exl), .ex_dst_i(exd),
    .ex_use_i(exu), .ex_src_i(exs), .mem_valid_i(mv), .mem_wen_i(mw),
    .mem_load_i(ml), .mem_dst_i(md), .wb_valid_i(wv), .wb_wen_i(ww), .wb_dst_i(wd),
    .stall_o(st1), .bubble_o(bb1), .issue_valid_o(iv1), .fwd_sel_o(f1));
  hz_unit #(.REG_BITS(RB), .NUM_SRC(NS), .FWD_MASK(2'b01)) u2 (
    .mode_interlock_i(mode), .dec_valid_i(dv), .dec_use_i(du), .dec_src_i(ds),
    .ex_valid_i(exv), .ex_wen_i(exw), .ex_load_i(exl), .ex_dst_i(exd),
    .ex_use_i(exu), .ex_src_i(exs), .mem_valid_i(mv), .mem_wen_i(mw),
    .mem_load_i(ml), .mem_dst_i(md), .wb_valid_i(wv), .wb_wen_i(ww), .wb_dst_i(wd),
    .stall_o(st2), .bubble_o(bb2), .issue_valid_o(iv2), .fwd_sel_o(f2));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic cmp(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    mode = v.mode; dv = v.dv; du = v.du; ds[1] = v.ds1; ds[0] = v.ds0;
    exv = v.exv; exw = v.exw; exl = v.exl; exd = v.exd; exu = v.exu;
    exs[1] = v.exs1; exs[0] = v.exs0;
    mv = v.mv; mw = v.mw; ml = v.ml; md = v.md;
    wv = v.wv; ww = v.ww; wd = v.wd;
  endtask

  initial begin
    apply(mk(0, 0,0,0,0,0, 0,0,0,0,0,0,0, 0,0,0,0, 0,0,0, 0,1,1));
    repeat (3) @(posedge clk);
    #4;
    // R9 state while held in reset: nothing stalls, operands read the register file
    cmp("R9", "reset stall", int'(st0 | st1 | st2), 0);
    cmp("R4", "reset sel", int'(f0), 'h09);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string rq;
      @(negedge clk);
      apply(TBL[i]);
      #4;
      rq = $sformatf("R%0d row%0d", TBL[i].rq, i);
      cmp(rq, "stall full", int'(st0), int'(TBL[i].est[0]));
      cmp(rq, "stall noXM", int'(st1), int'(TBL[i].est[1]));
      cmp(rq, "stall noMW", int'(st2), int'(TBL[i].est[2]));
      cmp({rq, " R9"}, "bubble", int'(bb0), int'(TBL[i].est[0]));
      cmp({rq, " R9"}, "issue_valid", int'(iv0), int'(TBL[i].dv && !TBL[i].est[0]));
      cmp(rq, "sel op0", int'(f0[0]), int'(TBL[i].ef0));
      cmp(rq, "sel op1", int'(f0[1]), int'(TBL[i].ef1));
    end

    // R7 and R8: masked builds pick only the paths they have (row 11 stimulus)
    @(negedge clk);
    apply(TBL[11]);
    #4;
    cmp("R7", "noXM sel op0", int'(f1[0]), 1);
    cmp("R7", "noXM sel op1", int'(f1[1]), 4);
    cmp("R8", "noMW sel op0", int'(f2[0]), 2);
    cmp("R8", "noMW sel op1", int'(f2[1]), 1);

    // R1 with masked builds: the load-use stall also reaches the bubble marker
    @(negedge clk);
    apply(TBL[1]);
    #4;
    cmp("R1", "noXM bubble", int'(bb1), 1);
    cmp("R1", "noMW issue_valid", int'(iv2), 0);

    // R9: decode invalid while a matching load sits in execute
    @(negedge clk);
    apply(mk(9, 1,0,3, 5,5, 1,1,1,5, 0,0,0, 1,1,0,5, 0,0,0, 0,1,1));
    #4;
    cmp("R9", "invalid decode stall", int'(st0 | st1 | st2), 0);
    cmp("R9", "invalid decode issue", int'(iv0), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule